// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This unit repairs an 8-bit accumulator after the datapath has added or subtracted two packed-BCD bytes in plain binary. It looks at the raw byte together with the three flags that the preceding operation left behind: the subtract flag, the half-carry flag and the carry flag. It then applies a correction of 0x06 to the low digit and 0x60 to the high digit, so that the byte becomes valid packed BCD again. The unit only adjusts a result that already exists. It does not perform the preceding arithmetic and it does not decode instructions.

The unit takes a single cycle. The operands are presented with `in_valid` high. On the next rising clock edge the registered outputs carry the corrected byte and the updated flags, and `out_valid` is asserted. When `in_valid` is low, the outputs keep their previous values. The add and subtract paths follow different rules. After an add, the correction is decided from the flags together with a range check on the digits. After a subtract, the correction is decided from the flags alone.

Top module: `bcd_adjust`

## Requirements
- R1: While `rst_n` is low, and after reset is released until the first accepted input, `out_valid`, `acc_out`, `z_out`, `n_out`, `h_out` and `c_out` are all 0.
- R2: An input accepted with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. `out_valid` is low in any cycle that follows a cycle with `in_valid` low.
- R3: While `in_valid` is low, `acc_out` and all flag outputs keep their values, whatever the other inputs do.
- R4: Add path (`n_in`=0): 0x06 is added when `h_in`=1 or when the low nibble `acc_in[3:0]` is greater than 9.
- R5: Add path: 0x60 is added when `c_in`=1 or when the original `acc_in` is greater than 0x99. This test is made before the low-digit correction. `c_out` is 1 exactly when this correction applies.
- R6: Subtract path (`n_in`=1): 0x06 is subtracted if and only if `h_in`=1, and 0x60 is subtracted if and only if `c_in`=1. The result wraps modulo 256, and no digit-range test is made.
- R7: Subtract path: `c_out` equals `c_in`.
- R8: `h_out` is 0 after every adjust.
- R9: `z_out` is 1 exactly when the corrected 8-bit result is 0x00.
- R10: `n_out` equals the `n_in` of the adjusted input.
- R11: Take any two packed-BCD bytes A and B (0..99). Suppose binary A+B or A−B is presented with its binary flags: H = carry out of bit 3 (or borrow into bit 4), C = carry out of bit 7 (or borrow). Then `acc_out` is the packed BCD of the decimal result modulo 100, and `c_out` is 1 exactly on decimal overflow (sum ≥ 100) or borrow (A < B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the accumulator and flags this cycle |
| acc_in | input | 8 | Binary result of the preceding add or subtract |
| n_in | input | 1 | Subtract flag from the preceding operation |
| h_in | input | 1 | Half-carry flag from the preceding operation |
| c_in | input | 1 | Carry flag from the preceding operation |
| out_valid | output | 1 | Corrected result is present |
| acc_out | output | 8 | Corrected packed-BCD byte |
| z_out | output | 1 | Result-is-zero flag |
| n_out | output | 1 | Subtract flag, passed through |
| h_out | output | 1 | Half-carry flag, always cleared |
| c_out | output | 1 | Carry flag after adjust |

## Verification
The assertions check several properties on every cycle:
- the one-cycle handshake and the holding of the outputs while idle;
- the cleared half-carry, the passed-through subtract flag and the zero flag;
- the carry kept on the subtract path and sticky on the add path;
- that no correction is made when no flag is set and both digits are already in range.

The exact correction amounts, and the boundary of the high-digit test at 0x99 against 0x9A, can only be shown by the bench. It drives a table of hand-picked corner bytes. It also runs every pair of BCD operands, in both add and subtract, and checks them against a decimal model.

// File: rtl/bcd_adjust.sv
module bcd_adjust (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] acc_in,
  input  logic       n_in,
  input  logic       h_in,
  input  logic       c_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic       z_out,
  output logic       n_out,
  output logic       h_out,
  output logic       c_out
);

  logic       lo_fix, hi_fix;
  logic [7:0] corr, res;

  // Range tests look at the original byte, so both use acc_in directly
  assign lo_fix = h_in | (~n_in & (acc_in[3:0] > 4'd9));
  assign hi_fix = c_in | (~n_in & (acc_in > 8'h99));
  assign corr   = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
  assign res    = n_in ? acc_in - corr : acc_in + corr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= 8'h00;
      z_out     <= 1'b0;
      n_out     <= 1'b0;
      h_out     <= 1'b0;
      c_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out <= res;
        z_out   <= (res == 8'h00);
        n_out   <= n_in;
        h_out   <= 1'b0;
        c_out   <= hi_fix;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_out) && $stable(z_out) && $stable(c_out) && $stable(n_out) && $stable(h_out)));
  assert_half_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !h_out);
  assert_n_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (n_out == $past(n_in)));
  assert_sub_carry_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && n_in) |=> (c_out == $past(c_in)));
  assert_add_carry_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !n_in && c_in) |=> c_out);
  assert_sub_no_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && n_in && !h_in && !c_in) |=> (acc_out == $past(acc_in)));
  assert_add_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !n_in && !h_in && !c_in && acc_in[3:0] <= 4'd9 && acc_in <= 8'h99)
      |=> (acc_out == $past(acc_in) && !c_out));
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (z_out == (acc_out == 8'h00)));

endmodule

// File: tb/bcd_adjust_bench.sv
module bcd_adjust_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] acc_in = 8'h00;
  logic       n_in = 1'b0, h_in = 1'b0, c_in = 1'b0;
  logic       out_valid, z_out, n_out, h_out, c_out;
  logic [7:0] acc_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bcd_adjust u_bcd_adjust (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
    .n_in(n_in), .h_in(h_in), .c_in(c_in), .out_valid(out_valid),
    .acc_out(acc_out), .z_out(z_out), .n_out(n_out), .h_out(h_out), .c_out(c_out)
  );

  // {acc, n, h, c, exp_acc, exp_z, exp_c}
  localparam int NV = 13;
  localparam logic [20:0] VEC [NV] = '{
    {8'h9A, 3'b000, 8'h00, 1'b1, 1'b1},
    {8'h0A, 3'b000, 8'h10, 1'b0, 1'b0},
    {8'h12, 3'b010, 8'h18, 1'b0, 1'b0},
    {8'hA0, 3'b000, 8'h00, 1'b1, 1'b1},
    {8'h15, 3'b001, 8'h75, 1'b0, 1'b1},
    {8'h9F, 3'b000, 8'h05, 1'b0, 1'b1},
    {8'h99, 3'b000, 8'h99, 1'b0, 1'b0},
    {8'hFF, 3'b111, 8'h99, 1'b0, 1'b1},
    {8'h1F, 3'b100, 8'h1F, 1'b0, 1'b0},
    {8'h06, 3'b110, 8'h00, 1'b1, 1'b0},
    {8'h50, 3'b101, 8'hF0, 1'b0, 1'b1},
    {8'h03, 3'b111, 8'h9D, 1'b0, 1'b1},
    {8'h00, 3'b000, 8'h00, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] a, logic n, logic h, logic c);
    @(negedge clk);
    in_valid = 1'b1; acc_in = a; n_in = n; h_in = h; c_in = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {10'd0, out_valid, acc_out, z_out, n_out, h_out, c_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {10'd0, out_valid, acc_out, z_out, n_out, h_out, c_out}, 16'h0);

    // Table of corner bytes: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10]);
      check("R2", {15'd0, out_valid}, 16'd1);
      check(VEC[i][12] ? "R6" : "R4_R5", {8'd0, acc_out}, {8'd0, VEC[i][9:2]});
      check("R9", {15'd0, z_out}, {15'd0, VEC[i][1]});
      check(VEC[i][12] ? "R7" : "R5", {15'd0, c_out}, {15'd0, VEC[i][0]});
      check("R8", {15'd0, h_out}, 16'd0);
      check("R10", {15'd0, n_out}, {15'd0, VEC[i][12]});
    end

    // R3: idle cycles with changing inputs leave outputs untouched
    apply(8'h2B, 1'b0, 1'b0, 1'b0);
    check("R4", {8'd0, acc_out}, 16'h0031);
    acc_in = 8'hFF; n_in = 1'b1; h_in = 1'b1; c_in = 1'b1;
    @(negedge clk);
    check("R2", {15'd0, out_valid}, 16'd0);
    check("R3", {10'd0, acc_out, z_out, n_out, h_out, c_out}, {10'd0, 8'h31, 4'b0000});
    @(negedge clk);
    check("R3", {10'd0, acc_out, z_out, n_out, h_out, c_out}, {10'd0, 8'h31, 4'b0000});

    // R11: every BCD operand pair, add and subtract
    for (int da = 0; da < 100; da++) begin
      for (int db = 0; db < 100; db++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] a, b, bin, exp_acc;
          logic h, c, exp_c;
          a = to_bcd(da); b = to_bcd(db);
          if (m == 0) begin
            bin = a + b;
            h = ((a & 8'h0F) + (b & 8'h0F)) > 8'h0F;
            c = (9'(a) + 9'(b)) > 9'h0FF;
            exp_acc = to_bcd((da + db) % 100);
            exp_c = (da + db) >= 100;
          end else begin
            bin = a - b;
            h = (a & 8'h0F) < (b & 8'h0F);
            c = a < b;
            exp_acc = to_bcd((da - db + 100) % 100);
            exp_c = da < db;
          end
          apply(bin, m[0], h, c);
          check("R11", {7'd0, acc_out, c_out}, {7'd0, exp_acc, exp_c});
        end
      end
    end

    // R1: reset mid-run clears outputs
    @(negedge clk);
    in_valid = 1'b1; acc_in = 8'h42;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {10'd0, out_valid, acc_out, z_out, n_out, h_out, c_out}, 16'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    done = 1;
    summary();
  end

endmodule